// File: doc/BRIEF.md
# Multiprocessor UART Receive Buffer and Status Registers

This block is the register face of an 8-bit UART's receive path, together with the transmit holding register that shares its data address. A serial front end, outside this block, handles bit shifting, baud timing and framing checks. When a frame is complete, the front end gives a one-cycle strobe together with the received byte, a flag that marks it as an address frame, and three error indications. The block decides whether to accept the frame. An accepted frame is copied into the receive buffer, a receive interrupt request is raised, and the error nibble of the status register is updated.

The bus sees two registers, chosen by a select bit. At the data address, a read returns the receive buffer and a write loads the transmit holding register. The status register carries four sticky error flags in its low nibble and the transmit and receive interrupt requests and enables in its high nibble. For multiprocessor operation, a level input tells the block to accept only address frames. While it is high, data frames leave no trace.

Top module: `uart_rx_regif`

## Requirements
- R1: With `bus_sel`=0, a read returns the receive buffer on `bus_rdata` in the same cycle. A write loads `bus_wdata` into the transmit holding register. `tx_data` shows the new value and `tx_load` is high for exactly the one cycle after the write edge.
- R2: A frame is accepted when `rx_done` is high and it is not filtered by R4. On the same clock edge, `rx_byte` is copied into the receive buffer and the receive request (status bit 5) is set.
- R3: The receive buffer keeps its value until the next accepted frame. Bus reads and writes do not alter it.
- R4: When `mp_addr_only`=1, a frame with `rx_is_addr`=0 is dropped. The buffer, status bit 5 and the error nibble stay unchanged, and the overrun tracking is not disturbed.
- R5: The error flags are bit 0 (parity), bit 2 (framing) and bit 3 (break). They are set from `rx_perr`, `rx_ferr` and `rx_brk` only at an accepted frame. Error inputs without an accepted frame have no effect.
- R6: Status bits 0 to 5 are sticky. A later clean frame never clears them. A status write (`bus_sel`=1) clears a bit where the written bit is 0 and leaves it where the written bit is 1. A set event in the same cycle wins over the clear.
- R7: Bit 1 (overrun) is set by an accepted frame if the buffer has not been read at the data address since the previous accepted frame. After reset the buffer counts as read. It follows that if software clears bit 1 without reading the buffer, the next accepted frame sets bit 1 again.
- R8: A `tx_ready` pulse sets bit 4 (transmit request). Bits 6 and 7 are the transmit and receive enables and are written directly. `irq_tx` equals bit 4 AND bit 6, and `irq_rx` equals bit 5 AND bit 7.
- R9: Synchronous active-low reset clears the status register to 0x00, drives `irq_rx`, `irq_tx` and `tx_load` low, and marks the buffer as read. The buffer contents are not defined after reset.
- R10: With `bus_sel`=1, a read returns the status register on `bus_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register select: 0 data, 1 status |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| rx_done | input | 1 | Frame-complete strobe from the front end |
| rx_byte | input | 8 | Received byte, valid with `rx_done` |
| rx_is_addr | input | 1 | Received frame is an address frame |
| rx_perr | input | 1 | Parity error of the completed frame |
| rx_ferr | input | 1 | Framing error of the completed frame |
| rx_brk | input | 1 | Break detected on the completed frame |
| mp_addr_only | input | 1 | Accept address frames only |
| tx_ready | input | 1 | Transmitter ready pulse |
| tx_data | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse after a transmit write |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
Two things can happen in the same cycle: a frame end and a bus access. A status write that clears a flag can meet a frame end that sets it, and a buffer read can meet a frame transfer that resets the read marker. Directed steps place a clearing write and a parity-error frame on the same edge, and the clear must lose. The random phase mixes frame strobes, reads and status writes at high density, so both kinds of coincidence occur many times. A bench model computes the new status from the old status, the write mask and the frame event, and every bus read is checked against that model.

// File: rtl/uart_rx_regif_pkg.sv
// Shared constants for the UART receive register interface.
// Assumes an 8-bit status register with a fixed bit layout.
package uart_rx_regif_pkg;
    localparam int STAT_W   = 8;
    localparam int ST_PERR  = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_FERR  = 2;
    localparam int ST_BRK   = 3;
    localparam int ST_TXREQ = 4;
    localparam int ST_RXREQ = 5;
    localparam int ST_TXEN  = 6;
    localparam int ST_RXEN  = 7;
    localparam int W0C_HI   = ST_RXREQ;   // bits 0..W0C_HI are write-0-to-clear

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_STAT = 1'b1
    } regsel_e;
endpackage

// File: rtl/rxr_buffer.sv
// Receive buffer with a "read since last transfer" marker.
// Assumes: accept is already filtered. The buffer itself is not reset,
// so its contents are undefined after reset. The marker resets to "read".
module rxr_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              data_rd,
    output logic [DATA_W-1:0] buf_q,
    output logic              unread
);
    logic read_mark_q;

    // Capture the received byte on an accepted frame end.
    always_ff @(posedge clk) begin
        if (accept) begin
            buf_q <= rx_byte;
        end
    end

    // Track whether the bus has read the buffer; a transfer wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_mark_q <= 1'b1;
        end else if (accept) begin
            read_mark_q <= 1'b0;
        end else if (data_rd) begin
            read_mark_q <= 1'b1;
        end
    end

    assign unread = ~read_mark_q;
endmodule

// File: rtl/rxr_status.sv
// Status register: sticky error nibble, interrupt requests and enables.
// Assumes single-cycle event strobes. Set events override a same-cycle
// write-0 clear. The enable bits are plain read/write.
module rxr_status
    import uart_rx_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              perr,
    input  logic              ferr,
    input  logic              brk,
    input  logic              ovr_evt,
    input  logic              tx_ready,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_d;

    // Next status: apply the software write first, then OR in hardware events.
    always_comb begin
        stat_d = stat_q;
        if (stat_wr) begin
            stat_d[W0C_HI:0]        = stat_q[W0C_HI:0] & wdata[W0C_HI:0];
            stat_d[STAT_W-1:W0C_HI+1] = wdata[STAT_W-1:W0C_HI+1];
        end
        if (accept) begin
            stat_d[ST_PERR]  = stat_d[ST_PERR] | perr;
            stat_d[ST_FERR]  = stat_d[ST_FERR] | ferr;
            stat_d[ST_BRK]   = stat_d[ST_BRK]  | brk;
            stat_d[ST_OVR]   = stat_d[ST_OVR]  | ovr_evt;
            stat_d[ST_RXREQ] = 1'b1;
        end
        if (tx_ready) begin
            stat_d[ST_TXREQ] = 1'b1;
        end
    end

    // Status register with synchronous clear to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/rxr_txhold.sv
// Transmit holding register and its load pulse toward the transmitter.
// Assumes the transmitter samples tx_data while tx_load is high.
module rxr_txhold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load
);
    // Hold the written byte and pulse tx_load for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= load;
            if (load) begin
                tx_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/uart_rx_regif.sv
// UART receive buffer/status register interface with multiprocessor filter.
// Assumes: the serial front end presents rx_byte and the error bits with a
// one-cycle rx_done. DATA_W must equal the 8-bit status width.
module uart_rx_regif
    import uart_rx_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_is_addr,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              mp_addr_only,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load,
    output logic              irq_rx,
    output logic              irq_tx
);
    regsel_e           sel;
    logic              accept;
    logic              unread;
    logic              data_rd;
    logic [DATA_W-1:0] rx_buf;
    logic [STAT_W-1:0] stat;

    // Decode the select and the frame filter.
    always_comb begin
        sel     = regsel_e'(bus_sel);
        accept  = rx_done & ~(mp_addr_only & ~rx_is_addr);
        data_rd = bus_rd & (sel == SEL_DATA);
    end

    rxr_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .rx_byte (rx_byte),
        .data_rd (data_rd),
        .buf_q   (rx_buf),
        .unread  (unread)
    );

    rxr_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .perr     (rx_perr),
        .ferr     (rx_ferr),
        .brk      (rx_brk),
        .ovr_evt  (accept & unread),
        .tx_ready (tx_ready),
        .stat_wr  (bus_wr & (sel == SEL_STAT)),
        .wdata    (bus_wdata[STAT_W-1:0]),
        .stat_q   (stat)
    );

    rxr_txhold #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bus_wr & (sel == SEL_DATA)),
        .wdata   (bus_wdata),
        .tx_data (tx_data),
        .tx_load (tx_load)
    );

    // Read mux and interrupt outputs.
    always_comb begin
        bus_rdata = (sel == SEL_STAT) ? DATA_W'(stat) : rx_buf;
        irq_rx    = stat[ST_RXREQ] & stat[ST_RXEN];
        irq_tx    = stat[ST_TXREQ] & stat[ST_TXEN];
    end
endmodule

// File: rtl/uart_rx_regif_chk.sv
// Assertion checker for uart_rx_regif, attached by bind.
module uart_rx_regif_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              rx_is_addr,
    input logic              mp_addr_only,
    input logic              bus_wr,
    input logic              bus_sel,
    input logic [DATA_W-1:0] rx_byte,
    input logic [DATA_W-1:0] rx_buf,
    input logic [7:0]        stat
);
    AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !(mp_addr_only && !rx_is_addr)) |=> (rx_buf == $past(rx_byte)) && stat[5]); // R2
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rx_buf)); // R3
    AST_FILTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mp_addr_only && !rx_is_addr && !(bus_wr && bus_sel)) |=> $stable(rx_buf) && $stable(stat[3:0])); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel) |=> ((stat[5:0] & $past(stat[5:0])) == $past(stat[5:0]))); // R6
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat == 8'h00)); // R9
endmodule

bind uart_rx_regif uart_rx_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_done      (rx_done),
    .rx_is_addr   (rx_is_addr),
    .mp_addr_only (mp_addr_only),
    .bus_wr       (bus_wr),
    .bus_sel      (bus_sel),
    .rx_byte      (rx_byte),
    .rx_buf       (rx_buf),
    .stat         (stat)
);

// File: tb/uart_rx_regif_bench.sv
`timescale 1ns/1ps
module uart_rx_regif_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       rx_done = 0, rx_is_addr = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_byte = 0;
    logic       mp_addr_only = 0, tx_ready = 0;
    logic [7:0] tx_data;
    logic       tx_load, irq_rx, irq_tx;

    int checks = 0, failures = 0;
    logic [7:0] m_buf = 0, m_stat = 0, m_tx = 0;
    logic       m_mark = 1, m_load = 0;
    logic [7:0] last_rd;
    bit         done_flag = 0;

    always #2 clk = ~clk;

    uart_rx_regif u_uart_rx_regif (.*);

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Next status from the requirements (R5..R8).
    function automatic logic [7:0] next_stat(input logic [7:0] s, input logic wr_s, input logic [7:0] wd,
                                             input logic acc, input logic mark, input logic pe,
                                             input logic fe, input logic bk, input logic txr);
        logic [7:0] n = s;
        if (wr_s) n = {wd[7:6], s[5:0] & wd[5:0]};
        if (acc) begin
            n[0] |= pe; n[1] |= ~mark; n[2] |= fe; n[3] |= bk; n[5] = 1'b1;
        end
        if (txr) n[4] = 1'b1;
        return n;
    endfunction

    // One cycle: drive at negedge, check read data, update model, check outputs.
    task automatic step(input logic rd, input logic wr, input logic sel, input logic [7:0] wd,
                        input logic dn, input logic isa, input logic mpo, input logic [7:0] byt,
                        input logic pe, input logic fe, input logic bk, input logic txr);
        logic acc;
        bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        rx_done = dn; rx_is_addr = isa; mp_addr_only = mpo; rx_byte = byt;
        rx_perr = pe; rx_ferr = fe; rx_brk = bk; tx_ready = txr;
        #1;
        if (rd) begin
            last_rd = bus_rdata;
            chk(bus_rdata == (sel ? m_stat : m_buf), sel ? "R10" : "R1", bus_rdata, sel ? m_stat : m_buf);
        end
        acc    = dn && !(mpo && !isa);
        m_stat = next_stat(m_stat, wr && sel, wd, acc, m_mark, pe, fe, bk, txr);
        if (acc) m_buf = byt;
        if (acc) m_mark = 1'b0; else if (rd && !sel) m_mark = 1'b1;
        m_load = wr && !sel;
        if (m_load) m_tx = wd;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; rx_done = 0; tx_ready = 0;
        chk(irq_rx == (m_stat[5] & m_stat[7]), "R8", {7'd0, irq_rx}, {7'd0, m_stat[5] & m_stat[7]});
        chk(irq_tx == (m_stat[4] & m_stat[6]), "R8", {7'd0, irq_tx}, {7'd0, m_stat[4] & m_stat[6]});
        chk(tx_load == m_load, "R1", {7'd0, tx_load}, {7'd0, m_load});
        if (m_load) chk(tx_data == m_tx, "R1", tx_data, m_tx);
    endtask

    task automatic idle();             step(0,0,0,8'h00, 0,0,0,8'h00, 0,0,0,0); endtask
    task automatic rd_data();          step(1,0,0,8'h00, 0,0,0,8'h00, 0,0,0,0); endtask
    task automatic rd_stat();          step(1,0,1,8'h00, 0,0,0,8'h00, 0,0,0,0); endtask
    task automatic wr_stat(input logic [7:0] v); step(0,1,1,v, 0,0,0,8'h00, 0,0,0,0); endtask
    task automatic frame(input logic [7:0] b, input logic isa, input logic mpo,
                         input logic pe, input logic fe, input logic bk);
        step(0,0,0,8'h00, 1,isa,mpo,b, pe,fe,bk,0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(irq_rx == 0 && irq_tx == 0 && tx_load == 0, "R9", {5'd0, irq_rx, irq_tx, tx_load}, 8'h00);
        rst_n = 1'b1;
        rd_stat(); chk(last_rd == 8'h00, "R9", last_rd, 8'h00);

        // R2: accepted frame loads buffer and sets receive request
        frame(8'hA5, 0, 0, 0, 0, 0);
        rd_data(); chk(last_rd == 8'hA5, "R2", last_rd, 8'hA5);
        rd_stat(); chk(last_rd == 8'h20, "R2", last_rd, 8'h20);
        wr_stat(8'hA0); chk(irq_rx == 1'b1, "R8", {7'd0, irq_rx}, 8'h01);

        // R3: buffer held across idle cycles and a transmit write
        idle(); idle(); step(0,1,0,8'h5A, 0,0,0,8'h00, 0,0,0,0);
        chk(tx_data == 8'h5A && tx_load, "R1", tx_data, 8'h5A);
        rd_data(); chk(last_rd == 8'hA5, "R3", last_rd, 8'hA5);

        // R5: error inputs without a frame end have no effect
        step(0,0,0,8'h00, 0,0,0,8'h11, 1,1,1,0);
        rd_stat(); chk(last_rd[3:0] == 4'h0, "R5", last_rd, {last_rd[7:4], 4'h0});

        // R4: filtered data frame leaves buffer and status untouched
        frame(8'h3C, 0, 1, 1, 1, 1);
        rd_data(); chk(last_rd == 8'hA5, "R4", last_rd, 8'hA5);
        rd_stat(); chk(last_rd[3:0] == 4'h0, "R4", last_rd, {last_rd[7:4], 4'h0});
        frame(8'h77, 1, 1, 0, 0, 0);
        rd_data(); chk(last_rd == 8'h77, "R4", last_rd, 8'h77);

        // R7: no overrun after read; overrun without read; re-set after clear without read
        frame(8'h01, 0, 0, 0, 0, 0);
        rd_stat(); chk(last_rd[1] == 1'b0, "R7", last_rd, last_rd & 8'hFD);
        frame(8'h02, 0, 0, 0, 0, 0);
        rd_stat(); chk(last_rd[1] == 1'b1, "R7", last_rd, last_rd | 8'h02);
        wr_stat(8'h80);
        frame(8'h03, 0, 0, 0, 0, 0);
        rd_stat(); chk(last_rd[1] == 1'b1, "R7", last_rd, last_rd | 8'h02);
        rd_data(); wr_stat(8'h80);
        frame(8'h04, 0, 0, 0, 0, 0);
        rd_stat(); chk(last_rd[1] == 1'b0, "R7", last_rd, last_rd & 8'hFD);

        // R6: sticky flags, write-1 keeps, write-0 clears, set wins over clear
        rd_data(); frame(8'h05, 0, 0, 0, 1, 0);
        rd_data(); frame(8'h06, 0, 0, 0, 0, 0);
        rd_stat(); chk(last_rd[2] == 1'b1, "R6", last_rd, last_rd | 8'h04);
        wr_stat(8'hFF); rd_stat(); chk(last_rd[2] == 1'b1, "R6", last_rd, last_rd | 8'h04);
        wr_stat(8'hFB); rd_stat(); chk(last_rd[2] == 1'b0, "R6", last_rd, last_rd & 8'hFB);
        rd_data();
        step(0,1,1,8'h40, 1,0,0,8'h09, 1,0,0,0);
        rd_stat(); chk(last_rd == 8'h61, "R6", last_rd, 8'h61);

        // R8: transmit-ready pulse sets request, irq_tx follows enable
        step(0,0,0,8'h00, 0,0,0,8'h00, 0,0,0,1);
        chk(irq_tx == 1'b1, "R8", {7'd0, irq_tx}, 8'h01);

        // Random mix of frames, reads, writes and filter settings
        for (int i = 0; i < 4000; i++) begin
            logic rd, wr, sel;
            rd  = ($urandom % 3) == 0;
            wr  = !rd && (($urandom % 4) == 0);
            sel = $urandom % 2;
            step(rd, wr, sel, 8'($urandom), ($urandom % 3) == 0, $urandom % 2, ($urandom % 4) == 0,
                 8'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 9) == 0,
                 ($urandom % 6) == 0);
        end
        rd_stat(); rd_data();

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule